// File: doc/BRIEF.md
# Endpoint multi-vector MSI generator

This block sits on the endpoint side of a PCIe link and turns internal event pulses into message-signalled interrupt write requests. Typical sources are a sample FIFO reaching full and a DMA transfer finishing. The root complex programs the interrupt through four 32-bit configuration words: a control word, a low and a high message address, and a message data word. Each accepted event produces one memory-write request descriptor. The descriptor carries the target address and a 32-bit data value, and it leaves on a valid/ready port for the transaction layer to turn into a packet.

The endpoint advertises how many vectors it supports. The root complex answers with a grant, and the grant decides how many low bits of the data word the block may overwrite with an event's vector number. With a grant of one vector, every event collapses onto the same data value. Events that arrive while an earlier request is stalled are held as pending bits. They are then issued one per handshake, with the lowest event index first. Event indices must be assigned in ascending vector order, so that this also means lowest vector first.

Top module: `msi_vector_gen`

## Requirements
- R1: After reset `req_valid` is 0, and the control word at byte offset 0x48 reads 0x00060005. That value is capability ID 0x05 in bits 7:0, next pointer 0 in bits 15:8, enable bit 16 at 0, advertised field bits 19:17 equal to CAP_LOG2 (3), grant bits 22:20 at 0 and wide-address bit 23 at 0.
- R2: The advertised field (bits 19:17 of the control word) is read-only: a write of all ones leaves it equal to CAP_LOG2.
- R3: A write to the grant field (bits 22:20) stores the written code when it is at most CAP_LOG2; any larger code, including 6 and 7, is stored as CAP_LOG2. Codes use log2 encoding: 0=1, 1=2, 2=4, 3=8 vectors.
- R4: While the enable bit 16 is 0, no request is raised. Events seen while disabled are discarded and produce no request after MSI is later enabled.
- R5: The request data equals the data word (offset 0x54) with its low G bits replaced by the low G bits of the event's vector number, where G is the grant code. Event 0 uses vector 0 and event 1 uses vector 5. With G=0 all events send the data word unchanged.
- R6: The request address has the low-address word (offset 0x4C) in bits 31:0, with bits 1:0 forced to 0. When bit 23 is 1, bits 63:32 carry the high word (offset 0x50) and `req_is64` is 1. When bit 23 is 0, bits 63:32 are 0 and `req_is64` is 0.
- R7: Events that are pending at the same time are issued lowest index first, one request per handshake.
- R8: While `req_valid` is 1 and `req_ready` is 0, the request address, width flag and data hold steady, even if the configuration words are rewritten.
- R9: With the block idle and enabled, an event sampled at clock edge k raises `req_valid` after edge k+1.
- R10: Repeated pulses of one event while its earlier request is still pending merge into a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| evt | input | NUM_EVT | Event pulses, one bit per source |
| req_valid | output | 1 | Write request is available |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 64 | Message address |
| req_is64 | output | 1 | Request uses the 64-bit address |
| req_data | output | 32 | Message data |

## Verification
The bench aims at grant values 0, 1, 2 and 3, with vector 5 chosen so that each mask width keeps a different part of it. A design that masked with the advertised field instead of the grant, or that forgot to collapse at grant 0, would send the wrong low data bits. Reserved and oversized grant writes check the clamp, since a design that stored them raw would widen the mask beyond what was advertised. Events pulsed while disabled, and re-pulsed while already pending, catch designs that replay stale interrupts or duplicate them. A stalled request whose configuration words are rewritten underneath it catches a payload taken combinationally rather than registered.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int VEC_W = 5;
  localparam logic [7:0] MSI_CAP_ID = 8'h05;

  function automatic logic [31:0] vec_mask(input logic [2:0] log2n);
    return (32'd1 << log2n) - 32'd1;
  endfunction

  function automatic logic [31:0] msg_data(input logic [31:0] base,
                                           input logic [2:0]  log2n,
                                           input logic [VEC_W-1:0] vec);
    logic [31:0] m;
    m = vec_mask(log2n);
    return (base & ~m) | ({{(32-VEC_W){1'b0}}, vec} & m);
  endfunction

  function automatic logic [2:0] clamp_grant(input logic [2:0] req, input logic [2:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  function automatic logic [63:0] msg_addr(input logic wide, input logic [31:0] hi,
                                           input logic [31:0] lo);
    return {(wide ? hi : 32'd0), lo[31:2], 2'b00};
  endfunction
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_pkg::*;
#(
  parameter int CAP_LOG2 = 3,
  parameter int CFG_AW   = 8,
  parameter int CTRL_OFS = 'h48,
  parameter int NEXT_PTR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              msi_en,
  output logic [2:0]        grant_log2,
  output logic              wide,
  output logic [31:0]       addr_lo,
  output logic [31:0]       addr_hi,
  output logic [31:0]       data_base
);
  localparam logic [CFG_AW-1:0] A_CTRL = CFG_AW'(CTRL_OFS);
  localparam logic [CFG_AW-1:0] A_LO   = CFG_AW'(CTRL_OFS + 4);
  localparam logic [CFG_AW-1:0] A_HI   = CFG_AW'(CTRL_OFS + 8);
  localparam logic [CFG_AW-1:0] A_DAT  = CFG_AW'(CTRL_OFS + 12);
  localparam logic [2:0]        CAP3   = 3'(CAP_LOG2);
  localparam logic [7:0]        NEXT8  = 8'(NEXT_PTR);

  logic [31:0] ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en     <= 1'b0;
      grant_log2 <= 3'd0;
      wide       <= 1'b0;
      addr_lo    <= 32'd0;
      addr_hi    <= 32'd0;
      data_base  <= 32'd0;
    end else if (cfg_wr) begin
      if (cfg_addr == A_CTRL) begin
        msi_en     <= cfg_wdata[16];
        grant_log2 <= clamp_grant(cfg_wdata[22:20], CAP3);
        wide       <= cfg_wdata[23];
      end
      if (cfg_addr == A_LO)  addr_lo   <= {cfg_wdata[31:2], 2'b00};
      if (cfg_addr == A_HI)  addr_hi   <= cfg_wdata;
      if (cfg_addr == A_DAT) data_base <= cfg_wdata;
    end
  end

  assign ctrl_word = {8'h00, wide, grant_log2, CAP3, msi_en, NEXT8, MSI_CAP_ID};

  always_comb begin
    cfg_rdata = 32'd0;
    if (cfg_addr == A_CTRL) cfg_rdata = ctrl_word;
    if (cfg_addr == A_LO)   cfg_rdata = addr_lo;
    if (cfg_addr == A_HI)   cfg_rdata = addr_hi;
    if (cfg_addr == A_DAT)  cfg_rdata = data_base;
  end
endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               take,
  output logic [NUM_EVT-1:0] pend,
  output logic [NUM_EVT-1:0] grant
);
  localparam logic [NUM_EVT-1:0] ONE = NUM_EVT'(1);

  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] served;

  assign grant  = pend_q & (~pend_q + ONE);
  assign served = take ? grant : '0;
  assign pend   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (!enable) pend_q <= '0;
    else              pend_q <= (pend_q & ~served) | evt;
  end
endmodule

// File: rtl/msi_req_out.sv
module msi_req_out (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [63:0] ld_addr,
  input  logic        ld_is64,
  input  logic [31:0] ld_data,
  input  logic        req_ready,
  output logic        free,
  output logic        req_valid,
  output logic [63:0] req_addr,
  output logic        req_is64,
  output logic [31:0] req_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= 64'd0;
      req_is64  <= 1'b0;
      req_data  <= 32'd0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_addr  <= ld_addr;
      req_is64  <= ld_is64;
      req_data  <= ld_data;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  assign free = !req_valid || req_ready;
endmodule

// File: rtl/msi_vector_gen.sv
module msi_vector_gen
  import msi_pkg::*;
#(
  parameter int NUM_EVT  = 2,
  parameter int CAP_LOG2 = 3,
  parameter logic [NUM_EVT*5-1:0] EVT_VEC = {5'd5, 5'd0},
  parameter int CFG_AW   = 8,
  parameter int CTRL_OFS = 'h48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_EVT-1:0] evt,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  output logic               req_is64,
  output logic [31:0]        req_data
);
  logic               msi_en, wide, free, load;
  logic [2:0]         grant_log2;
  logic [31:0]        addr_lo, addr_hi, data_base;
  logic [NUM_EVT-1:0] pend, grant;
  logic [VEC_W-1:0]   sel_vec;
  logic [VEC_W-1:0]   vec_of [NUM_EVT];

  msi_cap_regs #(.CAP_LOG2(CAP_LOG2), .CFG_AW(CFG_AW), .CTRL_OFS(CTRL_OFS), .NEXT_PTR(0)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .msi_en(msi_en), .grant_log2(grant_log2), .wide(wide),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data_base(data_base));

  msi_pend_arb #(.NUM_EVT(NUM_EVT)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(msi_en), .evt(evt), .take(load),
    .pend(pend), .grant(grant));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_vec
    assign vec_of[i] = EVT_VEC[i*VEC_W +: VEC_W];
  end

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (grant[i]) sel_vec = vec_of[i];
  end

  assign load = free && (|grant) && msi_en;

  msi_req_out u_out (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_addr(msg_addr(wide, addr_hi, addr_lo)), .ld_is64(wide),
    .ld_data(msg_data(data_base, grant_log2, sel_vec)),
    .req_ready(req_ready), .free(free), .req_valid(req_valid),
    .req_addr(req_addr), .req_is64(req_is64), .req_data(req_data));
endmodule

// File: rtl/msi_vector_gen_chk.sv
module msi_vector_gen_chk #(
  parameter int NUM_EVT  = 2,
  parameter int CAP_LOG2 = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msi_en,
  input logic [2:0]         grant_log2,
  input logic               load,
  input logic [NUM_EVT-1:0] pend,
  input logic [NUM_EVT-1:0] grant,
  input logic               req_valid,
  input logic               req_ready,
  input logic [63:0]        req_addr,
  input logic               req_is64,
  input logic [31:0]        req_data
);
  localparam logic [NUM_EVT-1:0] ONE = NUM_EVT'(1);

  AST_GRANT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_log2 <= 3'(CAP_LOG2)); // R3
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en && !req_valid) |=> !req_valid); // R4
  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is64) |-> (req_addr[63:32] == 32'd0 && req_addr[1:0] == 2'b00)); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (((grant - ONE) & pend) == '0)); // R7
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data) && $stable(req_addr)
                                   && $stable(req_is64))); // R8
  AST_LOAD_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> req_valid); // R9
endmodule

bind msi_vector_gen msi_vector_gen_chk #(.NUM_EVT(NUM_EVT), .CAP_LOG2(CAP_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .grant_log2(grant_log2), .load(load),
  .pend(pend), .grant(grant), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_is64(req_is64), .req_data(req_data));

// File: tb/tb_msi_vector_gen.sv
`timescale 1ns/1ps
module tb_msi_vector_gen;
  localparam int CAP = 3;
  localparam logic [4:0] V0 = 5'd0, V1 = 5'd5;
  localparam logic [7:0] A_CTRL = 8'h48, A_LO = 8'h4C, A_HI = 8'h50, A_DAT = 8'h54;

  logic clk = 0, rst_n = 0, cfg_wr = 0, req_ready = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, req_data;
  logic [1:0] evt = 0;
  logic req_valid, req_is64;
  logic [63:0] req_addr;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  msi_vector_gen dut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt(evt), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_is64(req_is64), .req_data(req_data));

  function automatic logic [31:0] exp_data(input logic [31:0] b, input int g, input logic [4:0] v);
    longint unsigned span;
    span = longint'(1) << g;
    return 32'((longint'(b) - (longint'(b) % span)) + (longint'(v) % span));
  endfunction

  function automatic logic [63:0] exp_addr(input logic w, input logic [31:0] hi, input logic [31:0] lo);
    logic [63:0] a;
    a = {32'd0, lo & 32'hFFFF_FFFC};
    if (w) a[63:32] = hi;
    return a;
  endfunction

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic set_ctrl(input logic en, input logic [2:0] g, input logic w);
    cfg_write(A_CTRL, {8'h00, w, g, 3'b000, en, 16'h0000});
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = 0;
  endtask

  task automatic get_req(input bit rnd, output logic [31:0] d, output logic [63:0] a,
                         output logic w, output bit ok);
    ok = 0; d = 0; a = 0; w = 0;
    for (int i = 0; i < 60 && !ok; i++) begin
      @(negedge clk);
      req_ready = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      if (req_valid && req_ready) begin d = req_data; a = req_addr; w = req_is64; ok = 1; end
    end
    @(negedge clk); req_ready = 0;
  endtask

  task automatic quiet(input int n, input string tag);
    logic seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); req_ready = 1;
      if (req_valid) seen = 1;
    end
    @(negedge clk); req_ready = 0;
    chk_eq(tag, seen, 0);
  endtask

  task automatic expect_req(input string tag, input logic [31:0] ed);
    logic [31:0] d; logic [63:0] a; logic w; bit ok;
    get_req(0, d, a, w, ok);
    chk_eq({tag, " handshake"}, ok, 1);
    chk_eq(tag, d, ed);
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] rd, d, base, lo, hi;
    logic [63:0] a;
    logic w;
    bit ok;
    void'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk_eq("R1 req_valid", req_valid, 0);
    cfg_read(A_CTRL, rd);
    chk_eq("R1 ctrl word", rd, 32'h0006_0005);

    // R2 read-only advertised field, R3 clamp
    cfg_write(A_CTRL, 32'hFFFF_FFFF);
    cfg_read(A_CTRL, rd);
    chk_eq("R2 cap field", rd[19:17], 3'(CAP));
    chk_eq("R3 grant 7 clamped", rd[22:20], 3'(CAP));
    set_ctrl(1, 3'd4, 0);
    cfg_read(A_CTRL, rd);
    chk_eq("R3 grant 4 clamped", rd[22:20], 3'(CAP));
    set_ctrl(1, 3'd2, 0);
    cfg_read(A_CTRL, rd);
    chk_eq("R3 grant 2 kept", rd[22:20], 3'd2);

    // R4 disabled: nothing sent, nothing replayed
    set_ctrl(0, 3'd2, 0);
    pulse(2'b11);
    quiet(10, "R4 disabled");
    set_ctrl(1, 3'd2, 0);
    quiet(10, "R4 no replay");

    // R9 latency, R8 hold under stall
    cfg_write(A_DAT, 32'hCAFE_0000);
    cfg_write(A_LO, 32'h0000_1003);
    @(negedge clk); evt = 2'b10;
    @(negedge clk); evt = 0;
    chk_eq("R9 not yet", req_valid, 0);
    @(negedge clk);
    chk_eq("R9 valid", req_valid, 1);
    cfg_write(A_DAT, 32'h1111_1111);
    cfg_write(A_LO, 32'h0000_2000);
    chk_eq("R8 data held", req_data, exp_data(32'hCAFE_0000, 2, V1));
    chk_eq("R8 addr held", req_addr, 64'h0000_0000_0000_1000);
    expect_req("R8 released", exp_data(32'hCAFE_0000, 2, V1));

    // R7 ordering and R5 collapse / widths
    cfg_write(A_DAT, 32'h1234_5670);
    pulse(2'b11);
    expect_req("R7 first g2", 32'h1234_5670);
    expect_req("R7 second g2", 32'h1234_5671);
    set_ctrl(1, 3'd0, 0);
    pulse(2'b11);
    expect_req("R5 g0 ev0", 32'h1234_5670);
    expect_req("R5 g0 ev1 collapsed", 32'h1234_5670);
    set_ctrl(1, 3'd3, 0);
    pulse(2'b11);
    expect_req("R5 g3 ev0", 32'h1234_5670);
    expect_req("R5 g3 ev1", 32'h1234_5675);

    // R10 merge of repeated pulses
    set_ctrl(1, 3'd1, 0);
    pulse(2'b01);
    pulse(2'b10);
    pulse(2'b10);
    expect_req("R10 ev0", 32'h1234_5670);
    expect_req("R10 ev1", 32'h1234_5671);
    quiet(10, "R10 single merged request");

    // R5 R6 R3 random mix
    for (int it = 0; it < 40; it++) begin
      int g, ge, e;
      g = $urandom_range(0, 7);
      ge = (g > CAP) ? CAP : g;
      w = 1'($urandom_range(0, 1));
      base = $urandom; lo = $urandom; hi = $urandom;
      e = $urandom_range(0, 1);
      cfg_write(A_DAT, base);
      cfg_write(A_LO, lo);
      cfg_write(A_HI, hi);
      set_ctrl(1, 3'(g), w);
      pulse(e == 0 ? 2'b01 : 2'b10);
      get_req(1, d, a, w, ok);
      chk_eq("R5 rnd handshake", ok, 1);
      chk_eq("R5 rnd data", d, exp_data(base, ge, e == 0 ? V0 : V1));
      chk_eq("R6 rnd addr", a, exp_addr(w, hi, lo));
    end

    // R6 directed widths
    cfg_write(A_LO, 32'hFEED_BEEF);
    cfg_write(A_HI, 32'h0000_00AB);
    set_ctrl(1, 3'd0, 1);
    pulse(2'b01);
    get_req(0, d, a, w, ok);
    chk_eq("R6 wide addr", a, 64'h0000_00AB_FEED_BEEC);
    chk_eq("R6 wide flag", w, 1);
    set_ctrl(1, 3'd0, 0);
    pulse(2'b01);
    get_req(0, d, a, w, ok);
    chk_eq("R6 narrow addr", a, 64'h0000_0000_FEED_BEEC);
    chk_eq("R6 narrow flag", w, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule